// File: doc/BRIEF.md
# Edge-Clearable Capture Timer

An up-counter driven by one of four clock-enable taps. It runs in one of two modes. In interval mode it only counts and, when enabled, raises an overflow flag each time it wraps. In capture mode it also watches an external capture pin. Each synchronised rising edge copies the count into a rising-edge capture register, and each falling edge copies it into a separate falling-edge capture register. The counter can also be zeroed by a chosen kind of edge. Software cannot read or write the counter. It sees the count only through the two capture registers.

A small register interface reaches four locations. Address 0 is the control register. Addresses 1 and 2 are the read-only falling-edge and rising-edge capture registers. Address 3 is a run/stop register whose bit 0 gates counting. The interrupt request is the overflow flag ANDed with an external enable input.

The capture pin passes through a flip-flop chain of `SYNC_STAGES` stages (2 by default). It is then gated by the mode bit and tracked by a two-state machine. In state `LVL_LOW`, a high gated level takes the transition `T_RISE` to `LVL_HIGH` and emits a rise pulse. In state `LVL_HIGH`, a low gated level takes the transition `T_FALL` back to `LVL_LOW` and emits a fall pulse. Otherwise each state holds (`T_HOLD_LOW`, `T_HOLD_HIGH`). Because the mode bit gates the level, changing the mode bit while the pin is high produces an edge event.

Top module: `cap_timer`

## Requirements
- R1: After reset the control register and both capture registers read 0x00, the run/stop register reads 0xFF and `irq` is 0.
- R2: The counter adds one on every clock where the selected tick enable is high and run bit 0 of address 3 is 1. It wraps from all ones to zero.
- R3: Control bits 1:0 choose which bit of `tick_en` advances the counter. Ticks on the other taps have no effect.
- R4: With control bit 3 at 0 (interval mode), activity on `cap_in` neither captures nor clears.
- R5: With control bit 3 at 1, a rising edge of `cap_in` copies the count into address 2 and a falling edge copies it into address 1. The register of the other polarity is left unchanged. The copy takes effect on the clock after the edge reaches the last synchroniser stage.
- R6: Control bits 5:4 pick the edge that clears the counter: 00 none, 01 falling, 10 rising, 11 both. The clear happens on the same clock as the capture, the capture keeps the pre-clear count, and a clear beats a coincident tick.
- R7: A wrap with overflow enable (control bit 6) at 1 sets the flag in control bit 7. A wrap with bit 6 at 0 leaves the flag clear.
- R8: The flag stays set until software writes 0 to bit 7. Writing 1 there has no effect, and a wrap in the same clock as a clearing write leaves the flag set.
- R9: `irq` is high exactly when the flag is set and `irq_en` is high.
- R10: Clearing bit 0 of the run/stop register freezes the counter.
- R11: Changing control bit 3 while `cap_in` is high acts as an edge: 0 to 1 captures into address 2, and 1 to 0 captures into address 1.
- R12: Writes to addresses 1 and 2 do not change the capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 4 | Prescaled clock enables, one per clock-select code |
| cap_in | input | 1 | Asynchronous capture pin |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with `bus_sel` |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench uses edge clears to zero the hidden counter and then applies exact tick bursts, so a captured value exposes an off-by-one or a wrong tap selection. It runs every clear-select code against both polarities. A design that decoded the field backwards would clear on the wrong edge, and every later capture would come out shifted. It switches the mode bit with the pin held high to provoke both synthetic edges. It toggles the pin in interval mode, where a design that failed to gate the pin would capture or zero the count. It drives a wrap in the same clock as a flag-clearing write. A design that gave the write priority would drop the flag.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    localparam int CTRL_W   = 8;
    localparam int SEL_W    = 2;
    localparam int N_TAPS   = 1 << SEL_W;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CAPF = 2'd1,
        ADDR_CAPR = 2'd2,
        ADDR_STOP = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_FALL = 2'b01,
        CLR_RISE = 2'b10,
        CLR_BOTH = 2'b11
    } clr_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    typedef struct packed {
        logic             ovie;
        clr_e             clr;
        logic             mode;
        logic             spare;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

endpackage

// File: rtl/cap_edge_fsm.sv
module cap_edge_fsm
    import cap_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_in,
    input  logic arm,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   lvl;
    lvl_state_e             state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= cap_in;
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    assign lvl = arm & chain_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // Transitions: T_RISE, T_FALL, T_HOLD_LOW, T_HOLD_HIGH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl) state_d = LVL_LOW;
        endcase
    end

    // Outputs
    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise = lvl;
            LVL_HIGH: fall = !lvl;
        endcase
    end

    // R5: an edge pulse leaves the tracker in the matching level state
    a_r5_rise_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state_q == LVL_HIGH));
    a_r5_fall_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (state_q == LVL_LOW));

endmodule

// File: rtl/cap_counter.sv
module cap_counter
    import cap_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             rise,
    input  logic             fall,
    input  clr_e             clr_mode,
    input  logic             ovie,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_rise,
    output logic [CNT_W-1:0] cap_fall,
    output logic             ovf_flag
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             clr_evt;
    logic             step;
    logic             wrap;

    always_comb begin
        unique case (clr_mode)
            CLR_NONE: clr_evt = 1'b0;
            CLR_FALL: clr_evt = fall;
            CLR_RISE: clr_evt = rise;
            CLR_BOTH: clr_evt = rise | fall;
        endcase
    end

    assign step = tick & run;
    assign wrap = step & !clr_evt & (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr_evt) cnt_q <= '0;
        else if (step)    cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_rise <= '0;
            cap_fall <= '0;
        end else begin
            if (rise) cap_rise <= cnt_q;
            if (fall) cap_fall <= cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)             ovf_flag <= 1'b0;
        else if (wrap && ovie)  ovf_flag <= 1'b1;
        else if (flag_clr)      ovf_flag <= 1'b0;
    end

    a_r5_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cap_rise == $past(cnt_q)));
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (cnt_q == '0));
    a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr_evt && cnt_q == CNT_TOP && ovie) |=> ovf_flag);
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);
    a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_evt) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/cap_regs.sv
module cap_regs
    import cap_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] cap_rise,
    input  logic [CNT_W-1:0] cap_fall,
    input  logic             ovf_flag,
    output logic [CNT_W-1:0] bus_rdata,
    output ctrl_t            ctrl,
    output logic             run,
    output logic             flag_clr
);

    logic [CNT_W-1:0] stop_q;
    logic             wr_ctrl;
    logic             wr_stop;
    addr_e            addr;

    assign addr    = addr_e'(bus_addr);
    assign wr_ctrl = bus_sel & bus_wr & (addr == ADDR_CTRL);
    assign wr_stop = bus_sel & bus_wr & (addr == ADDR_STOP);
    assign flag_clr = wr_ctrl & !bus_wdata[CTRL_W-1];
    assign run     = stop_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_W-2:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       stop_q <= '1;
        else if (wr_stop) stop_q <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            ADDR_CTRL: bus_rdata[CTRL_W-1:0] = {ovf_flag, ctrl};
            ADDR_CAPF: bus_rdata = cap_fall;
            ADDR_CAPR: bus_rdata = cap_rise;
            ADDR_STOP: bus_rdata = stop_q;
        endcase
    end

    // R10: the run bit only moves on a write to the run/stop register
    a_r10_run_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stop |=> (run == $past(run)));

endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TAPS-1:0] tick_en,
    input  logic              cap_in,
    input  logic              irq_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    ctrl_t            ctrl;
    logic             run;
    logic             flag_clr;
    logic             rise;
    logic             fall;
    logic             tick;
    logic             ovf_flag;
    logic [CNT_W-1:0] cap_rise;
    logic [CNT_W-1:0] cap_fall;

    assign tick = tick_en[ctrl.sel];
    assign irq  = ovf_flag & irq_en;

    cap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cap_rise  (cap_rise),
        .cap_fall  (cap_fall),
        .ovf_flag  (ovf_flag),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .run       (run),
        .flag_clr  (flag_clr)
    );

    cap_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_in (cap_in),
        .arm    (ctrl.mode),
        .rise   (rise),
        .fall   (fall)
    );

    cap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .rise     (rise),
        .fall     (fall),
        .clr_mode (ctrl.clr),
        .ovie     (ctrl.ovie),
        .flag_clr (flag_clr),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall),
        .ovf_flag (ovf_flag)
    );

    // R4: in interval mode no edge event reaches the counter
    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.mode && !$past(ctrl.mode)) |-> !(rise || fall));
    // R9: request follows flag and enable
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && irq_en));

endmodule

// File: tb/cap_timer_test.sv
module cap_timer_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tick_en = '0;
    logic       cap_in = 1'b0;
    logic       irq_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_in(cap_in),
        .irq_en(irq_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        check(req, v, e);
    endtask

    task automatic ticks(input int n, input int idx);
        @(negedge clk);
        tick_en = 4'(1 << idx);
        repeat (n) @(negedge clk);
        tick_en = '0;
    endtask

    task automatic pin(input logic v);
        @(negedge clk);
        cap_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        expect_reg("R1 ctrl", 2'd0, 8'h00);
        expect_reg("R1 capf", 2'd1, 8'h00);
        expect_reg("R1 capr", 2'd2, 8'h00);
        expect_reg("R1 stop", 2'd3, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_count;
        wr(2'd0, 8'h38);
        pin(1'b1);
        expect_reg("R5 first rise", 2'd2, 8'h00);
        ticks(10, 0);
        pin(1'b0);
        expect_reg("R2 R5 fall capture", 2'd1, 8'd10);
        ticks(7, 0);
        pin(1'b1);
        expect_reg("R2 R5 rise capture", 2'd2, 8'd7);
        expect_reg("R5 fall untouched", 2'd1, 8'd10);
    endtask

    task automatic t_clksel;
        wr(2'd0, 8'h3A);
        ticks(5, 0);
        ticks(6, 2);
        pin(1'b0);
        expect_reg("R3 tap select", 2'd1, 8'd6);
    endtask

    task automatic t_clear_modes;
        wr(2'd0, 8'h18);
        ticks(3, 0); pin(1'b1);
        expect_reg("R6 fall-only rise", 2'd2, 8'd3);
        ticks(4, 0); pin(1'b0);
        expect_reg("R6 fall-only fall", 2'd1, 8'd7);
        ticks(2, 0); pin(1'b1);
        expect_reg("R6 cleared by fall", 2'd2, 8'd2);
        wr(2'd0, 8'h28);
        ticks(3, 0); pin(1'b0);
        expect_reg("R6 rise-only fall", 2'd1, 8'd5);
        ticks(1, 0); pin(1'b1);
        expect_reg("R6 rise-only rise", 2'd2, 8'd6);
        ticks(2, 0); pin(1'b0);
        expect_reg("R6 cleared by rise", 2'd1, 8'd2);
        wr(2'd0, 8'h08);
        ticks(3, 0); pin(1'b1);
        expect_reg("R6 no-clear rise", 2'd2, 8'd5);
        ticks(1, 0); pin(1'b0);
        expect_reg("R6 no-clear fall", 2'd1, 8'd6);
    endtask

    task automatic t_mode0;
        wr(2'd0, 8'h30);
        pin(1'b1);
        pin(1'b0);
        expect_reg("R4 no rise capture", 2'd2, 8'd5);
        expect_reg("R4 no fall capture", 2'd1, 8'd6);
        ticks(2, 0);
        wr(2'd0, 8'h38);
        pin(1'b1);
        expect_reg("R4 no clear in interval", 2'd2, 8'd8);
    endtask

    task automatic t_spurious;
        wr(2'd0, 8'h08);
        wr(2'd0, 8'h00);
        repeat (3) @(negedge clk);
        expect_reg("R11 mode off edge", 2'd1, 8'd0);
        ticks(4, 0);
        wr(2'd0, 8'h08);
        repeat (3) @(negedge clk);
        expect_reg("R11 mode on edge", 2'd2, 8'd4);
    endtask

    task automatic t_overflow;
        wr(2'd0, 8'h38);
        pin(1'b0);
        wr(2'd0, 8'h08);
        ticks(256, 0);
        expect_reg("R7 no flag w/o enable", 2'd0, 8'h08);
        wr(2'd0, 8'h48);
        ticks(255, 0);
        expect_reg("R7 before wrap", 2'd0, 8'h48);
        ticks(1, 0);
        expect_reg("R7 flag set", 2'd0, 8'hC8);
        irq_en = 1'b0; #1;
        check("R9 irq masked", {7'd0, irq}, 8'h00);
        irq_en = 1'b1; #1;
        check("R9 irq raised", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'hC8);
        expect_reg("R8 write 1 keeps", 2'd0, 8'hC8);
        wr(2'd0, 8'h48);
        expect_reg("R8 write 0 clears", 2'd0, 8'h48);
        #1 check("R9 irq dropped", {7'd0, irq}, 8'h00);
        ticks(255, 0);
        @(negedge clk);
        tick_en = 4'b0001;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h48;
        @(negedge clk);
        tick_en = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        expect_reg("R8 set beats clear", 2'd0, 8'hC8);
        wr(2'd0, 8'h48);
        irq_en = 1'b0;
    endtask

    task automatic t_stop;
        wr(2'd3, 8'hFE);
        expect_reg("R10 stop readback", 2'd3, 8'hFE);
        ticks(5, 0);
        pin(1'b1);
        expect_reg("R10 frozen", 2'd2, 8'd0);
        wr(2'd3, 8'hFF);
        ticks(3, 0);
        pin(1'b0);
        expect_reg("R10 resumed", 2'd1, 8'd3);
    endtask

    task automatic t_readonly;
        wr(2'd1, 8'hAA);
        wr(2'd2, 8'h55);
        expect_reg("R12 capf ro", 2'd1, 8'd3);
        expect_reg("R12 capr ro", 2'd2, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_clksel();
        t_clear_modes();
        t_mode0();
        t_spurious();
        t_overflow();
        t_stop();
        t_readonly();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule